// File: doc/BRIEF.md
# Eight-Bit Waveform Timer with Two Compare Channels

This block is an 8-bit counter that advances on timer ticks and drives two compare outputs. The tick source is a free-running prescaler tap (divide by 1, 8, 64, 256 or 1024), a synchronised edge on an external pin, or nothing at all, which halts the counter. Four counting modes are provided: a plain wrapping count, a count that restarts when it reaches the channel A compare value, a single-slope PWM mode and a dual-slope (up then down) PWM mode.

Each channel compares the counter with its active compare value. On a match the channel raises a sticky flag and, depending on its output mode field, sets, clears or toggles its output. In the two PWM modes the compare value that software writes is held in a buffer, and it reaches the comparator only when the counter is at its top. A force strobe applies a channel's action at once, but only in the non-PWM modes. The counter also raises an overflow flag, and the cycle in which it does so depends on the mode. Software reaches everything through a small register bus that has a single-cycle write and a combinational read.

Top module: `tmr8_pwm_timer`

## Requirements
- R1: After reset, every register reads 0x00 (control at address 0, output config 1, force 2, count 3, compare A 4, compare B 5, flags 6), both compare outputs and all flags are low, and the timer is halted.
- R2: With control[1:0]=0 (wrapping mode), each tick increments the count (address 3). A tick taken at 0xFF gives 0x00 and sets the overflow flag (flags bit 0) in the same clock edge.
- R3: With control[1:0]=1 (restart mode), a tick taken while the count equals the active compare A value returns the count to 0x00, and the overflow flag stays low.
- R4: In the non-PWM modes a write to compare A/B is active from the next cycle. In the PWM modes (control[1:0]=2 single-slope, 3 dual-slope) the written value becomes active only on a tick taken at count 0xFF, and reading the compare address returns the written value.
- R5: A tick taken while the count equals a channel's active compare value sets that channel's match flag (flags bit 1 for A, bit 2 for B) at the same edge. In the non-PWM modes the channel output then follows its 2-bit field in output config (A in bits [1:0], B in bits [3:2]): 0 no change, 1 toggle, 2 clear, 3 set.
- R6: A change to a channel's output mode field does not change the output. The new action applies at the next match.
- R7: Writing 1 to force bit 0 (A) or bit 1 (B) applies that channel's action at the next edge in the non-PWM modes and leaves the match flag untouched. In the PWM modes the strobe does nothing.
- R8: In single-slope PWM with the field at 2, a tick at count 0x00 sets the output and a tick at a match clears it, with the match taking priority. A tick at 0xFF wraps the count and sets the overflow flag. Field 3 gives the inverse.
- R9: In dual-slope PWM the count rises to 0xFF, stays there for one tick, then falls to 0x00 and rises again. The overflow flag sets on a tick taken at 0x00.
- R10: In dual-slope PWM with the field at 2, an active compare of 0x00 keeps the output low and 0xFF keeps it high. Otherwise a match clears the output while rising and sets it while falling.
- R11: Control[4:2] selects the tick source: 0 halt, 1 every clock, 2 every 8th, 3 every 64th, 4 every 256th, 5 every 1024th clock, using a free-running prescaler.
- R12: Control[4:2]=7 ticks once per rising edge of the external pin and 6 once per falling edge, after a two-flop synchroniser.
- R13: Writing 1 to a flag bit clears it and writing 0 leaves it set. A flag event in the same cycle wins over the clear. A write to the count address loads the counter, and the load takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_clk_pin | input | 1 | External tick source, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| cmp_out | output | 2 | Compare outputs, bit 0 channel A, bit 1 channel B |
| ovf_flag | output | 1 | Overflow flag |
| match_flag | output | 2 | Match flags, bit 0 channel A, bit 1 channel B |

## Verification
The bench looks for the errors most likely to hide in this block. A new compare value written during single-slope PWM must not produce a match before the counter reaches its top; a design without that buffer would flag the match early. In dual-slope mode the counter has to dwell at 0xFF and signal overflow only at the bottom, so a design that overflowed at the top or reversed without the dwell would read back the wrong count. Compare values of 0x00 and 0xFF are run through a full dual-slope period and must give steady output levels rather than narrow glitches. The force strobe must be ignored in PWM and must not set a flag, and every prescaler tap is counted over an exact window, so a wrong divider tap or an edge detector that triggers on the wrong polarity shows up as a wrong tick count.

// File: rtl/tmr8_pkg.sv
// Shared encodings for the 8-bit waveform timer: modes, tick sources,
// channel output actions and the register address map.
package tmr8_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'd0,
        WM_CTC    = 2'd1,
        WM_FAST   = 2'd2,
        WM_PHASE  = 2'd3
    } wave_mode_e;

    typedef enum logic [2:0] {
        CS_STOP     = 3'd0,
        CS_DIV1     = 3'd1,
        CS_DIV8     = 3'd2,
        CS_DIV64    = 3'd3,
        CS_DIV256   = 3'd4,
        CS_DIV1024  = 3'd5,
        CS_EXT_FALL = 3'd6,
        CS_EXT_RISE = 3'd7
    } clk_sel_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLEAR  = 2'd2,
        OM_SET    = 2'd3
    } out_mode_e;

    localparam int ADDR_W  = 3;
    localparam int N_CH    = 2;
    localparam int LOG2_D8    = 3;
    localparam int LOG2_D64   = 6;
    localparam int LOG2_D256  = 8;
    localparam int LOG2_D1024 = 10;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_OUTCFG = 3'd1;
    localparam logic [ADDR_W-1:0] A_FORCE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP0   = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 3'd6;

    function automatic logic is_pwm(wave_mode_e m);
        return (m == WM_FAST) || (m == WM_PHASE);
    endfunction

endpackage

// File: rtl/tmr8_tick_gen.sv
// Tick source: a free-running prescaler with power-of-two taps plus a
// synchronised edge detector on the external pin.
// Assumes ext_pin is asynchronous; two flops resynchronise it.
module tmr8_tick_gen
    import tmr8_pkg::*;
#(
    parameter int PRESC_W = LOG2_D1024
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e sel,
    input  logic     ext_pin,
    output logic     tick
);
    logic [PRESC_W-1:0] presc_q;
    logic [2:0]         ext_q;
    logic               ext_rise, ext_fall;

    // Prescaler runs continuously so every tap keeps a fixed period.
    always_ff @(posedge clk) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    // Synchroniser (bits 0,1) and edge history (bit 2) for the external pin.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= {ext_q[1:0], ext_pin};
    end

    assign ext_rise = ext_q[1] & ~ext_q[2];
    assign ext_fall = ~ext_q[1] & ext_q[2];

    // Tap selection: a tap fires when its low prescaler bits are all ones.
    always_comb begin
        unique case (sel)
            CS_STOP:     tick = 1'b0;
            CS_DIV1:     tick = 1'b1;
            CS_DIV8:     tick = &presc_q[LOG2_D8-1:0];
            CS_DIV64:    tick = &presc_q[LOG2_D64-1:0];
            CS_DIV256:   tick = &presc_q[LOG2_D256-1:0];
            CS_DIV1024:  tick = &presc_q[LOG2_D1024-1:0];
            CS_EXT_FALL: tick = ext_fall;
            CS_EXT_RISE: tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/tmr8_counter.sv
// Counter core: advances on tick according to the waveform mode, reports
// direction, the overflow event and the top-of-count buffer update event.
// Assumes top_cmp is the active (already buffered) channel A compare value.
module tmr8_counter
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wave_mode_e       mode,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] top_cmp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             count_up,
    output logic             ovf_evt,
    output logic             top_upd
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic             dir_up_q, dir_d;
    logic [CNT_W-1:0] cnt_d;
    logic             advance;

    assign advance  = tick && !load;
    assign count_up = dir_up_q;

    // Next count and direction for each waveform mode.
    always_comb begin
        cnt_d = cnt_q + CNT_ONE;
        dir_d = 1'b1;
        unique case (mode)
            WM_NORMAL, WM_FAST: cnt_d = cnt_q + CNT_ONE;
            WM_CTC: cnt_d = (cnt_q == top_cmp) ? '0 : cnt_q + CNT_ONE;
            WM_PHASE: begin
                if (dir_up_q) begin
                    if (cnt_q == CNT_MAX) begin
                        dir_d = 1'b0;
                        cnt_d = CNT_MAX - CNT_ONE;
                    end
                end else if (cnt_q == '0) begin
                    cnt_d = CNT_ONE;
                end else begin
                    dir_d = 1'b0;
                    cnt_d = cnt_q - CNT_ONE;
                end
            end
        endcase
    end

    // Overflow at MAX wrap, except dual-slope where it marks BOTTOM.
    assign ovf_evt = advance && ((mode == WM_PHASE) ? (cnt_q == '0) : (cnt_q == CNT_MAX));
    // Buffered compare values load on a tick taken at the top.
    assign top_upd = advance && is_pwm(mode) && (cnt_q == CNT_MAX);

    // Count register: bus load wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            dir_up_q <= 1'b1;
        end else if (load) begin
            cnt_q    <= load_val;
        end else if (tick) begin
            cnt_q    <= cnt_d;
            dir_up_q <= dir_d;
        end
    end

    // R2
    normal_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && mode == WM_NORMAL) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
    // R3
    ctc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && mode == WM_CTC && cnt_q == top_cmp) |=> (cnt_q == '0));
    // R9
    phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && mode == WM_PHASE && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX - CNT_ONE));
endmodule

// File: rtl/tmr8_cmp_chan.sv
// One output-compare channel: compare buffer, match detection and the
// output waveform for every mode. Assumes cnt/count_up come from the counter.
module tmr8_cmp_chan
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wave_mode_e       mode,
    input  out_mode_e        out_mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             count_up,
    input  logic             top_upd,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic             force_stb,
    output logic [CNT_W-1:0] cmp_act,
    output logic             match_evt,
    output logic             wave_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic pwm, hit, upd, lvl, out_d;

    assign pwm       = is_pwm(mode);
    assign hit       = tick && (cnt == cmp_act);
    assign match_evt = hit;

    // Active compare: direct in non-PWM modes, loaded at top in PWM modes.
    always_ff @(posedge clk) begin
        if (!rst_n)             cmp_act <= '0;
        else if (!pwm || top_upd) cmp_act <= cmp_buf;
    end

    // Output decision: upd says whether to drive, lvl the non-inverted level.
    always_comb begin
        upd = 1'b0;
        lvl = wave_out;
        unique case (mode)
            WM_FAST: begin
                if (hit) begin
                    upd = 1'b1; lvl = 1'b0;
                end else if (tick && cnt == '0) begin
                    upd = 1'b1; lvl = 1'b1;
                end
            end
            WM_PHASE: begin
                if (tick) begin
                    if (cmp_act == '0) begin
                        upd = 1'b1; lvl = 1'b0;
                    end else if (cmp_act == CNT_MAX) begin
                        upd = 1'b1; lvl = 1'b1;
                    end else if (hit) begin
                        upd = 1'b1; lvl = !count_up;
                    end
                end
            end
            default: begin
                if (hit || force_stb) begin
                    upd = 1'b1;
                    unique case (out_mode)
                        OM_TOGGLE: lvl = !wave_out;
                        OM_CLEAR:  lvl = 1'b0;
                        OM_SET:    lvl = 1'b1;
                        OM_OFF:    upd = 1'b0;
                    endcase
                end
            end
        endcase
        out_d = wave_out;
        if (pwm) begin
            if (upd && out_mode == OM_CLEAR)    out_d = lvl;
            else if (upd && out_mode == OM_SET) out_d = !lvl;
        end else if (upd) begin
            out_d = lvl;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) wave_out <= 1'b0;
        else        wave_out <= out_d;
    end

    // R4
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !top_upd) |=> $stable(cmp_act));
    // R7
    force_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && pwm && !tick) |=> $stable(wave_out));
    // R10
    phase_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && mode == WM_PHASE && out_mode == OM_CLEAR && cmp_act == '0) |=> !wave_out);
endmodule

// File: rtl/tmr8_pwm_timer.sv
// Top: register bus, flags and wiring of tick source, counter and channels.
// Assumes single-cycle writes and a combinational read path.
module tmr8_pwm_timer
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_pin,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [N_CH-1:0]   cmp_out,
    output logic              ovf_flag,
    output logic [N_CH-1:0]   match_flag
);
    wave_mode_e            mode_q;
    clk_sel_e              cs_q;
    logic [N_CH-1:0][1:0]  om_q;
    logic [CNT_W-1:0]      cmp_buf_q [N_CH];
    logic [CNT_W-1:0]      cmp_act_w [N_CH];
    logic [N_CH-1:0]       match_evt_w, match_q, match_clr;
    logic [CNT_W-1:0]      cnt_w;
    logic                  tick, count_up, ovf_evt, top_upd, ovf_q;
    logic                  wr_ctrl, wr_outcfg, wr_force, wr_count, wr_flags;

    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_outcfg = bus_wr && (bus_addr == A_OUTCFG);
    assign wr_force  = bus_wr && (bus_addr == A_FORCE);
    assign wr_count  = bus_wr && (bus_addr == A_COUNT);
    assign wr_flags  = bus_wr && (bus_addr == A_FLAGS);
    assign match_clr = wr_flags ? bus_wdata[N_CH:1] : '0;

    // Control and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WM_NORMAL;
            cs_q   <= CS_STOP;
            om_q   <= '0;
            for (int i = 0; i < N_CH; i++) cmp_buf_q[i] <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q <= wave_mode_e'(bus_wdata[1:0]);
                cs_q   <= clk_sel_e'(bus_wdata[4:2]);
            end
            if (wr_outcfg) om_q <= bus_wdata[2*N_CH-1:0];
            for (int i = 0; i < N_CH; i++)
                if (bus_wr && bus_addr == ADDR_W'(int'(A_CMP0) + i))
                    cmp_buf_q[i] <= bus_wdata;
        end
    end

    // Sticky flags: an event wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q   <= 1'b0;
            match_q <= '0;
        end else begin
            ovf_q   <= ovf_evt | (ovf_q & ~(wr_flags & bus_wdata[0]));
            match_q <= match_evt_w | (match_q & ~match_clr);
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:   bus_rdata[4:0] = {cs_q, mode_q};
            A_OUTCFG: bus_rdata[2*N_CH-1:0] = om_q;
            A_COUNT:  bus_rdata = cnt_w;
            A_FLAGS:  bus_rdata[N_CH:0] = {match_q, ovf_q};
            default:  bus_rdata = '0;
        endcase
        for (int i = 0; i < N_CH; i++)
            if (bus_addr == ADDR_W'(int'(A_CMP0) + i)) bus_rdata = cmp_buf_q[i];
    end

    tmr8_tick_gen u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cs_q),
        .ext_pin (ext_clk_pin),
        .tick    (tick)
    );

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (mode_q),
        .load     (wr_count),
        .load_val (bus_wdata),
        .top_cmp  (cmp_act_w[0]),
        .cnt_q    (cnt_w),
        .count_up (count_up),
        .ovf_evt  (ovf_evt),
        .top_upd  (top_upd)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        tmr8_cmp_chan #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode_q),
            .out_mode  (out_mode_e'(om_q[g])),
            .tick      (tick),
            .cnt       (cnt_w),
            .count_up  (count_up),
            .top_upd   (top_upd),
            .cmp_buf   (cmp_buf_q[g]),
            .force_stb (wr_force && bus_wdata[g]),
            .cmp_act   (cmp_act_w[g]),
            .match_evt (match_evt_w[g]),
            .wave_out  (cmp_out[g])
        );
    end

    assign ovf_flag   = ovf_q;
    assign match_flag = match_q;

    // R13
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
    // R13
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && bus_wdata[0] && !ovf_evt) |=> !ovf_flag);
endmodule

// File: tb/tmr8_pwm_timer_tb_top.sv
// Directed bench for the 8-bit waveform timer.
module tmr8_pwm_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] AD_CTRL = 3'd0, AD_OCFG = 3'd1, AD_FORCE = 3'd2,
                           AD_CNT = 3'd3, AD_CMPA = 3'd4, AD_CMPB = 3'd5, AD_FLAGS = 3'd6;
    localparam logic [1:0] M_NORM = 2'd0, M_CTC = 2'd1, M_FAST = 2'd2, M_PHASE = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_pin = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cmp_out;
    logic       ovf_flag;
    logic [1:0] match_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr8_pwm_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_pin (ext_clk_pin),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cmp_out     (cmp_out),
        .ovf_flag    (ovf_flag),
        .match_flag  (match_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Runs exactly n clock edges with tick source cs, then halts the timer.
    task automatic run(input logic [1:0] m, input logic [2:0] cs, input int n);
        wr(AD_CTRL, {3'b000, cs, m});
        repeat (n - 1) @(negedge clk);
        wr(AD_CTRL, {3'b000, 3'd0, m});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 register reset", v, 0);
        end
        chk("R1 outputs reset", {cmp_out, match_flag, ovf_flag}, 0);
        repeat (50) @(negedge clk);
        rd(AD_CNT, v);
        chk("R11 halted after reset", v, 0);
    endtask

    task automatic t_normal;
        logic [7:0] v;
        wr(AD_CNT, 8'hFD);
        rd(AD_CNT, v);
        chk("R13 count load", v, 8'hFD);
        run(M_NORM, 3'd1, 2);
        rd(AD_CNT, v);
        chk("R2 count to FF", v, 8'hFF);
        chk("R2 no overflow before wrap", ovf_flag, 0);
        run(M_NORM, 3'd1, 1);
        rd(AD_CNT, v);
        chk("R2 wrap to 00", v, 0);
        chk("R2 overflow at wrap", ovf_flag, 1);
        wr(AD_FLAGS, 8'h00);
        chk("R13 write zero keeps flag", ovf_flag, 1);
        wr(AD_FLAGS, 8'h01);
        chk("R13 write one clears flag", ovf_flag, 0);
    endtask

    task automatic t_ctc;
        logic [7:0] v;
        wr(AD_CMPA, 8'h05);
        wr(AD_CNT, 8'h00);
        wr(AD_FLAGS, 8'h07);
        run(M_CTC, 3'd1, 5);
        rd(AD_CNT, v);
        chk("R3 count reaches compare", v, 5);
        chk("R5 no match yet", match_flag[0], 0);
        run(M_CTC, 3'd1, 1);
        rd(AD_CNT, v);
        chk("R3 restart at compare", v, 0);
        chk("R5 match flag A", match_flag[0], 1);
        rd(AD_FLAGS, v);
        chk("R5 flags register bit 1", v[1], 1);
        chk("R3 no overflow in restart mode", ovf_flag, 0);
    endtask

    task automatic t_toggle;
        wr(AD_FLAGS, 8'h07);
        wr(AD_OCFG, 8'h01);
        wr(AD_CMPA, 8'h03);
        wr(AD_CMPB, 8'h00);
        wr(AD_CNT, 8'h00);
        run(M_NORM, 3'd1, 3);
        chk("R5 output before match", cmp_out[0], 0);
        run(M_NORM, 3'd1, 1);
        chk("R5 toggle on match", cmp_out[0], 1);
        chk("R5 field 0 leaves B unchanged", cmp_out[1], 0);
        chk("R5 match flag B still sets", match_flag[1], 1);
        wr(AD_OCFG, 8'h02);
        repeat (3) @(negedge clk);
        chk("R6 mode change alone no effect", cmp_out[0], 1);
        wr(AD_CNT, 8'h03);
        run(M_NORM, 3'd1, 1);
        chk("R6 new action at next match", cmp_out[0], 0);
    endtask

    task automatic t_force;
        wr(AD_FLAGS, 8'h07);
        wr(AD_OCFG, 8'h0E);
        wr(AD_FORCE, 8'h02);
        chk("R7 force sets B", cmp_out[1], 1);
        chk("R7 force sets no flag", match_flag[1], 0);
        wr(AD_OCFG, 8'h0A);
        wr(AD_CTRL, {3'b000, 3'd0, M_FAST});
        wr(AD_FORCE, 8'h02);
        @(negedge clk);
        chk("R7 force ignored in PWM", cmp_out[1], 1);
    endtask

    task automatic t_fast;
        logic [7:0] v;
        wr(AD_CTRL, {3'b000, 3'd0, M_NORM});
        wr(AD_CMPA, 8'h10);
        wr(AD_CTRL, {3'b000, 3'd0, M_FAST});
        wr(AD_CMPA, 8'h08);
        rd(AD_CMPA, v);
        chk("R4 compare readback", v, 8'h08);
        wr(AD_CNT, 8'h05);
        wr(AD_FLAGS, 8'h07);
        run(M_FAST, 3'd1, 4);
        chk("R4 buffered value not active before top", match_flag[0], 0);
        wr(AD_OCFG, 8'h02);
        wr(AD_CNT, 8'hFE);
        wr(AD_FLAGS, 8'h07);
        run(M_FAST, 3'd1, 10);
        chk("R8 set at bottom", cmp_out[0], 1);
        chk("R8 overflow at top", ovf_flag, 1);
        chk("R4 no match before new value", match_flag[0], 0);
        run(M_FAST, 3'd1, 1);
        chk("R8 clear at match", cmp_out[0], 0);
        chk("R4 value active after top", match_flag[0], 1);
    endtask

    task automatic t_phase;
        logic [7:0] v;
        wr(AD_CTRL, {3'b000, 3'd0, M_PHASE});
        wr(AD_FLAGS, 8'h07);
        wr(AD_CNT, 8'hFD);
        run(M_PHASE, 3'd1, 2);
        rd(AD_CNT, v);
        chk("R9 rises to FF", v, 8'hFF);
        run(M_PHASE, 3'd1, 1);
        rd(AD_CNT, v);
        chk("R9 turns down after top", v, 8'hFE);
        chk("R9 no overflow at top", ovf_flag, 0);
        wr(AD_CNT, 8'h02);
        run(M_PHASE, 3'd1, 2);
        rd(AD_CNT, v);
        chk("R9 falls to 00", v, 0);
        chk("R9 no overflow yet", ovf_flag, 0);
        run(M_PHASE, 3'd1, 1);
        rd(AD_CNT, v);
        chk("R9 turns up after bottom", v, 1);
        chk("R9 overflow at bottom", ovf_flag, 1);
    endtask

    task automatic t_extremes;
        int bad = 0;
        wr(AD_CTRL, {3'b000, 3'd0, M_NORM});
        wr(AD_CMPA, 8'h00);
        wr(AD_CMPB, 8'hFF);
        wr(AD_OCFG, 8'h0A);
        wr(AD_CTRL, {3'b000, 3'd1, M_PHASE});
        repeat (3) @(negedge clk);
        for (int i = 0; i < 600; i++) begin
            if (cmp_out !== 2'b10) bad++;
            @(negedge clk);
        end
        wr(AD_CTRL, {3'b000, 3'd0, M_PHASE});
        chk("R10 steady levels at 00 and FF", bad, 0);
    endtask

    task automatic t_presc;
        logic [7:0] v;
        wr(AD_CNT, 8'h00); run(M_NORM, 3'd2, 64);   rd(AD_CNT, v); chk("R11 divide by 8", v, 8);
        wr(AD_CNT, 8'h00); run(M_NORM, 3'd3, 256);  rd(AD_CNT, v); chk("R11 divide by 64", v, 4);
        wr(AD_CNT, 8'h00); run(M_NORM, 3'd4, 1024); rd(AD_CNT, v); chk("R11 divide by 256", v, 4);
        wr(AD_CNT, 8'h00); run(M_NORM, 3'd5, 2048); rd(AD_CNT, v); chk("R11 divide by 1024", v, 2);
    endtask

    task automatic t_ext;
        logic [7:0] v;
        ext_clk_pin = 1'b0;
        repeat (5) @(negedge clk);
        wr(AD_CNT, 8'h00);
        wr(AD_CTRL, {3'b000, 3'd7, M_NORM});
        for (int i = 0; i < 5; i++) begin
            ext_clk_pin = ~ext_clk_pin;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        wr(AD_CTRL, {3'b000, 3'd0, M_NORM});
        rd(AD_CNT, v);
        chk("R12 rising edges", v, 3);
        ext_clk_pin = 1'b0;
        repeat (5) @(negedge clk);
        wr(AD_CNT, 8'h00);
        wr(AD_CTRL, {3'b000, 3'd6, M_NORM});
        for (int i = 0; i < 5; i++) begin
            ext_clk_pin = ~ext_clk_pin;
            repeat (4) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        wr(AD_CTRL, {3'b000, 3'd0, M_NORM});
        rd(AD_CNT, v);
        chk("R12 falling edges", v, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_ctc();
        t_toggle();
        t_force();
        t_fast();
        t_phase();
        t_extremes();
        t_presc();
        t_ext();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule